// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This unit holds the twelve-bit interrupt status word of an I2C controller that can act as bus master or slave. The protocol engine sends it one-cycle event pulses (general call, start, stop, slave NACK, transmit abort, slave read request). The host side sends write and read strobes for the FIFOs, and the bus side sends a byte-received strobe. The unit also sees both FIFO fill levels, two programmed thresholds, the controller enable and a busy flag from the bus state machines. From these inputs it keeps sticky event bits, computes level bits from the FIFO fill levels and detects overflow and underflow from the levels.

Software clears each sticky bit by reading that bit's clear register. The unit receives these reads as a strobe vector whose bit positions match the status word. A global clear strobe clears all sticky bits at once. The unit drives a masked interrupt line. It also drives two hold outputs: one keeps the transmit FIFO flushed after an abort, and the other keeps SCL stretched while a slave read request is waiting for service.

Top module: `i2c_irq_status`

## Requirements
- R1: After reset every status bit is 0 and irq is 0. The status bit positions are: 11 gen_call, 10 start, 9 stop, 8 activity, 7 rx_done, 6 tx_abrt, 5 rd_req, 4 tx_empty, 3 tx_over, 2 rx_full, 1 rx_over, 0 rx_under.
- R2: A pulse on ev_gen_call, ev_start, ev_stop, ev_slv_nack, ev_tx_abort or ev_rd_req sets bit 11, 10, 9, 7, 6 or 5 respectively, in the cycle after the pulse. The bit then holds until a clear. A pulse on clr_rd at that same bit position clears it in the next cycle.
- R3: When an event and the clear strobe for the same bit arrive in the same cycle, the bit ends up set.
- R4: clr_all clears every sticky bit (11, 10, 9, 8, 7, 6, 5, 3, 1, 0) in the next cycle.
- R5: Bit 8 is set after any cycle in which enable and eng_busy are both high. It stays set after eng_busy falls.
- R6: Any cycle with enable low clears bits 11 and 8, and the clear takes priority over their set conditions.
- R7: While enabled, bit 4 is 1 exactly when tx_lvl <= tx_thr, and bit 2 is 1 exactly when rx_lvl >= rx_thr. Both bits follow their inputs in the same cycle.
- R8: While disabled, bit 4 equals eng_busy and bit 2 is 0.
- R9: Bit 3 is set by host_tx_wr when tx_lvl equals TX_DEPTH. Bit 1 is set by bus_rx_byte when rx_lvl equals RX_DEPTH. Bit 0 is set by host_rx_rd when rx_lvl is 0. The same strobe at any other level leaves the bit unchanged.
- R10: While disabled, bits 3, 1 and 0 hold their value as long as eng_busy is high, and they clear after a cycle in which eng_busy is low.
- R11: tx_flush_hold is high exactly while bit 6 is set, and scl_hold is high exactly while bit 5 is set.
- R12: irq is high exactly when some bit is set in both status and irq_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable |
| eng_busy | input | 1 | Master or slave state machine not idle |
| ev_gen_call | input | 1 | General call received and acknowledged |
| ev_start | input | 1 | START or repeated START seen on the bus |
| ev_stop | input | 1 | STOP seen on the bus |
| ev_slv_nack | input | 1 | Master did not acknowledge a byte sent by the slave |
| ev_tx_abort | input | 1 | Transmit abort |
| ev_rd_req | input | 1 | Addressed as a slave for a read |
| host_tx_wr | input | 1 | Host write into the TX FIFO |
| host_rx_rd | input | 1 | Host read from the RX FIFO |
| bus_rx_byte | input | 1 | Byte received from the bus |
| tx_lvl | input | TX_LW | TX FIFO fill level |
| tx_thr | input | TX_LW | TX threshold |
| rx_lvl | input | RX_LW | RX FIFO fill level |
| rx_thr | input | RX_LW | RX threshold |
| clr_rd | input | 12 | Per-bit clear-register read strobes |
| clr_all | input | 1 | Global clear-register read strobe |
| irq_mask | input | 12 | Interrupt enable mask |
| status | output | 12 | Interrupt status word |
| irq | output | 1 | Masked interrupt |
| tx_flush_hold | output | 1 | Keep the TX FIFO flushed |
| scl_hold | output | 1 | Keep SCL held low |

## Verification
The bench builds the unit with TX_DEPTH 8 and RX_DEPTH 4, which gives 4-bit and 3-bit level ports. With these sizes the FIFO-full boundaries that trigger overflow are small values the bench can drive directly. The table can also cover both threshold extremes, 0 and the full depth, for each FIFO. Using two different depths also shows whether each overflow compare uses the depth parameter of its own FIFO.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
   localparam int STAT_W     = 12;
   localparam int B_RXUNDER  = 0;
   localparam int B_RXOVER   = 1;
   localparam int B_RXFULL   = 2;
   localparam int B_TXOVER   = 3;
   localparam int B_TXEMPTY  = 4;
   localparam int B_RDREQ    = 5;
   localparam int B_TXABRT   = 6;
   localparam int B_RXDONE   = 7;
   localparam int B_ACT      = 8;
   localparam int B_STOP     = 9;
   localparam int B_START    = 10;
   localparam int B_GCALL    = 11;
   // bits held in flops; the rest are derived from FIFO levels
   localparam logic [STAT_W-1:0] STICKY_MASK   = 12'hFEB;
   // bits forced low whenever the controller is disabled
   localparam logic [STAT_W-1:0] OFF_KILL_MASK = 12'h900;
   // bits forced low once disabled and the engine is idle
   localparam logic [STAT_W-1:0] IDLE_KILL_MASK = 12'h00B;
endpackage

// File: rtl/i2c_irq_sticky.sv
module i2c_irq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic kill_i,
   output logic q
);
   // priority: kill, then set, then software clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (kill_i) q <= 1'b0;
      else if (set_i)  q <= 1'b1;
      else if (clr_i)  q <= 1'b0;
   end
endmodule

// File: rtl/i2c_irq_levels.sv
module i2c_irq_levels #(
   parameter int TX_LW = 7,
   parameter int RX_LW = 7
) (
   input  logic             enable,
   input  logic             eng_busy,
   input  logic [TX_LW-1:0] tx_lvl,
   input  logic [TX_LW-1:0] tx_thr,
   input  logic [RX_LW-1:0] rx_lvl,
   input  logic [RX_LW-1:0] rx_thr,
   output logic             tx_empty,
   output logic             rx_full
);
   // a disabled TX FIFO looks empty, reported only while the engine runs
   always_comb begin
      tx_empty = enable ? (tx_lvl <= tx_thr) : eng_busy;
      rx_full  = enable && (rx_lvl >= rx_thr);
   end
endmodule

// File: rtl/i2c_irq_status.sv
module i2c_irq_status
   import i2c_irq_pkg::*;
#(
   parameter int TX_DEPTH = 64,
   parameter int RX_DEPTH = 64,
   localparam int TX_LW = $clog2(TX_DEPTH + 1),
   localparam int RX_LW = $clog2(RX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              eng_busy,
   input  logic              ev_gen_call,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              ev_slv_nack,
   input  logic              ev_tx_abort,
   input  logic              ev_rd_req,
   input  logic              host_tx_wr,
   input  logic              host_rx_rd,
   input  logic              bus_rx_byte,
   input  logic [TX_LW-1:0]  tx_lvl,
   input  logic [TX_LW-1:0]  tx_thr,
   input  logic [RX_LW-1:0]  rx_lvl,
   input  logic [RX_LW-1:0]  rx_thr,
   input  logic [STAT_W-1:0] clr_rd,
   input  logic              clr_all,
   input  logic [STAT_W-1:0] irq_mask,
   output logic [STAT_W-1:0] status,
   output logic              irq,
   output logic              tx_flush_hold,
   output logic              scl_hold
);
   generate
      if (TX_DEPTH < 2) begin : g_bad_tx
         $error("TX_DEPTH must be at least 2");
      end
      if (RX_DEPTH < 2) begin : g_bad_rx
         $error("RX_DEPTH must be at least 2");
      end
   endgenerate

   localparam logic [TX_LW-1:0] TX_FULL = TX_LW'(TX_DEPTH);
   localparam logic [RX_LW-1:0] RX_FULL = RX_LW'(RX_DEPTH);

   logic [STAT_W-1:0] set_v, kill_v, level_v;
   logic              lv_tx_empty, lv_rx_full;

   i2c_irq_levels #(.TX_LW(TX_LW), .RX_LW(RX_LW)) u_levels (
      .enable   (enable),
      .eng_busy (eng_busy),
      .tx_lvl   (tx_lvl),
      .tx_thr   (tx_thr),
      .rx_lvl   (rx_lvl),
      .rx_thr   (rx_thr),
      .tx_empty (lv_tx_empty),
      .rx_full  (lv_rx_full)
   );

   always_comb begin
      set_v            = '0;
      set_v[B_GCALL]   = ev_gen_call;
      set_v[B_START]   = ev_start;
      set_v[B_STOP]    = ev_stop;
      set_v[B_ACT]     = enable && eng_busy;
      set_v[B_RXDONE]  = ev_slv_nack;
      set_v[B_TXABRT]  = ev_tx_abort;
      set_v[B_RDREQ]   = ev_rd_req;
      set_v[B_TXOVER]  = host_tx_wr  && (tx_lvl == TX_FULL);
      set_v[B_RXOVER]  = bus_rx_byte && (rx_lvl == RX_FULL);
      set_v[B_RXUNDER] = host_rx_rd  && (rx_lvl == '0);

      level_v              = '0;
      level_v[B_TXEMPTY]   = lv_tx_empty;
      level_v[B_RXFULL]    = lv_rx_full;

      kill_v = (OFF_KILL_MASK & {STAT_W{!enable}})
             | (IDLE_KILL_MASK & {STAT_W{!enable && !eng_busy}});
   end

   genvar b;
   generate
      for (b = 0; b < STAT_W; b++) begin : g_bit
         if (STICKY_MASK[b]) begin : g_sticky
            i2c_irq_sticky u_cell (
               .clk    (clk),
               .rst_n  (rst_n),
               .set_i  (set_v[b]),
               .clr_i  (clr_rd[b] || clr_all),
               .kill_i (kill_v[b]),
               .q      (status[b])
            );
         end else begin : g_level
            assign status[b] = level_v[b];
         end
      end
   endgenerate

   assign irq           = |(status & irq_mask);
   assign tx_flush_hold = status[B_TXABRT];
   assign scl_hold      = status[B_RDREQ];
endmodule

// File: rtl/i2c_irq_status_chk.sv
module i2c_irq_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        enable,
   input logic        eng_busy,
   input logic        ev_start,
   input logic        ev_stop,
   input logic        ev_rd_req,
   input logic [11:0] clr_rd,
   input logic        clr_all,
   input logic [11:0] status,
   input logic        scl_hold
);
   // R2
   start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> status[10]);
   // R3
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && (clr_rd[9] || clr_all)) |=> status[9]);
   // R4
   clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !ev_start) |=> !status[10]);
   // R6
   off_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!status[11] && !status[8]));
   // R10
   idle_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !eng_busy) |=> (status[3:0] & 4'b1011) == 4'b0000);
   // R11
   scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rd_req |=> scl_hold);
   // R8
   off_rxfull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !status[2]);
endmodule

bind i2c_irq_status i2c_irq_status_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .eng_busy  (eng_busy),
   .ev_start  (ev_start),
   .ev_stop   (ev_stop),
   .ev_rd_req (ev_rd_req),
   .clr_rd    (clr_rd),
   .clr_all   (clr_all),
   .status    (status),
   .scl_hold  (scl_hold)
);

// File: tb/i2c_irq_status_test.sv
module i2c_irq_status_test;
   localparam int TXD = 8;
   localparam int RXD = 4;
   localparam int TXW = $clog2(TXD + 1);
   localparam int RXW = $clog2(RXD + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, eng_busy = 1'b0;
   logic ev_gen_call = 1'b0, ev_start = 1'b0, ev_stop = 1'b0, ev_slv_nack = 1'b0;
   logic ev_tx_abort = 1'b0, ev_rd_req = 1'b0;
   logic host_tx_wr = 1'b0, host_rx_rd = 1'b0, bus_rx_byte = 1'b0;
   logic [TXW-1:0] tx_lvl = TXW'(5), tx_thr = TXW'(2);
   logic [RXW-1:0] rx_lvl = RXW'(1), rx_thr = RXW'(4);
   logic [11:0] clr_rd = '0, irq_mask = '0;
   logic clr_all = 1'b0;
   logic [11:0] status;
   logic irq, tx_flush_hold, scl_hold;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   i2c_irq_status #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .eng_busy(eng_busy),
      .ev_gen_call(ev_gen_call), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_slv_nack(ev_slv_nack), .ev_tx_abort(ev_tx_abort), .ev_rd_req(ev_rd_req),
      .host_tx_wr(host_tx_wr), .host_rx_rd(host_rx_rd), .bus_rx_byte(bus_rx_byte),
      .tx_lvl(tx_lvl), .tx_thr(tx_thr), .rx_lvl(rx_lvl), .rx_thr(rx_thr),
      .clr_rd(clr_rd), .clr_all(clr_all), .irq_mask(irq_mask),
      .status(status), .irq(irq), .tx_flush_hold(tx_flush_hold), .scl_hold(scl_hold)
   );

   // {tx_lvl, tx_thr, rx_lvl, rx_thr, enable, busy, exp_tx_empty, exp_rx_full}
   localparam int NV = 7;
   localparam logic [19:0] VEC [NV] = '{
      {4'd2, 4'd2, 4'd4, 4'd4, 1'b1, 1'b0, 1'b1, 1'b1},
      {4'd3, 4'd2, 4'd3, 4'd4, 1'b1, 1'b0, 1'b0, 1'b0},
      {4'd0, 4'd0, 4'd4, 4'd4, 1'b1, 1'b0, 1'b1, 1'b1},
      {4'd8, 4'd7, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1},
      {4'd8, 4'd0, 4'd4, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0},
      {4'd0, 4'd5, 4'd3, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0},
      {4'd7, 4'd7, 4'd2, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   task automatic fire(input int b);
      case (b)
         11: ev_gen_call = 1'b1;
         10: ev_start    = 1'b1;
         9:  ev_stop     = 1'b1;
         7:  ev_slv_nack = 1'b1;
         6:  ev_tx_abort = 1'b1;
         5:  ev_rd_req   = 1'b1;
         default: ;
      endcase
      tick();
      {ev_gen_call, ev_start, ev_stop, ev_slv_nack, ev_tx_abort, ev_rd_req} = '0;
   endtask

   task automatic clear_bit(input int b);
      clr_rd[b] = 1'b1;
      tick();
      clr_rd = '0;
   endtask

   initial begin
      #400000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      // R1 reset state
      tick(); tick();
      check("R1 status", 32'(status), 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      rst_n = 1'b1;
      tick();
      enable = 1'b1;
      tick();
      check("R1 idle enabled", 32'(status), 32'h0);

      // R7 R8 level table
      for (int i = 0; i < NV; i++) begin
         tx_lvl = TXW'(VEC[i][19:16]);
         tx_thr = TXW'(VEC[i][15:12]);
         rx_lvl = RXW'(VEC[i][11:8]);
         rx_thr = RXW'(VEC[i][7:4]);
         enable = VEC[i][3];
         eng_busy = VEC[i][2];
         tick();
         check(VEC[i][3] ? "R7 tx_empty" : "R8 tx_empty", 32'(status[4]), 32'(VEC[i][1]));
         check(VEC[i][3] ? "R7 rx_full" : "R8 rx_full", 32'(status[2]), 32'(VEC[i][0]));
      end
      enable = 1'b1; eng_busy = 1'b0;
      tx_lvl = TXW'(5); tx_thr = TXW'(2); rx_lvl = RXW'(1); rx_thr = RXW'(4);
      tick();

      // R2 sticky event bits, R11 hold outputs
      for (int k = 0; k < 6; k++) begin
         int b;
         b = (k < 3) ? 11 - k : 10 - k;
         fire(b);
         check("R2 set", 32'(status), 32'(12'h1 << b));
         tick();
         check("R2 hold", 32'(status), 32'(12'h1 << b));
         if (b == 6) check("R11 tx_flush_hold", 32'(tx_flush_hold), 32'h1);
         if (b == 5) check("R11 scl_hold", 32'(scl_hold), 32'h1);
         clear_bit(b);
         check("R2 clear", 32'(status), 32'h0);
      end
      check("R11 holds released", 32'({tx_flush_hold, scl_hold}), 32'h0);

      // R3 event beats clear
      ev_stop = 1'b1; clr_rd[9] = 1'b1;
      tick();
      ev_stop = 1'b0; clr_rd = '0;
      check("R3 event wins", 32'(status[9]), 32'h1);

      // R12 masked interrupt
      irq_mask = 12'h400;
      tick();
      check("R12 masked off", 32'(irq), 32'h0);
      fire(10);
      check("R12 masked on", 32'(irq), 32'h1);
      irq_mask = 12'h010;
      tx_lvl = TXW'(1);
      #1;
      check("R12 level bit", 32'(irq), 32'h1);
      tx_lvl = TXW'(5);
      irq_mask = '0;

      // R4 global clear
      fire(11); fire(6); fire(5);
      clr_all = 1'b1;
      tick();
      clr_all = 1'b0;
      check("R4 clear all", 32'(status), 32'h0);

      // R5 activity sticky
      eng_busy = 1'b1;
      tick();
      check("R5 activity set", 32'(status[8]), 32'h1);
      eng_busy = 1'b0;
      tick(); tick();
      check("R5 activity stays", 32'(status[8]), 32'h1);

      // R6 disable kills gen_call and activity
      fire(11);
      check("R6 gen_call before", 32'(status[11]), 32'h1);
      enable = 1'b0; eng_busy = 1'b1; ev_gen_call = 1'b1;
      tick();
      ev_gen_call = 1'b0;
      check("R6 off clears", 32'({status[11], status[8]}), 32'h0);
      enable = 1'b1; eng_busy = 1'b0;
      tick();

      // R9 overflow / underflow qualification
      tx_lvl = TXW'(7); host_tx_wr = 1'b1;
      tick();
      host_tx_wr = 1'b0;
      check("R9 tx write not full", 32'(status[3]), 32'h0);
      tx_lvl = TXW'(8); host_tx_wr = 1'b1;
      tick();
      host_tx_wr = 1'b0;
      check("R9 tx_over", 32'(status[3]), 32'h1);
      rx_lvl = RXW'(3); bus_rx_byte = 1'b1;
      tick();
      bus_rx_byte = 1'b0;
      check("R9 rx byte not full", 32'(status[1]), 32'h0);
      rx_lvl = RXW'(4); bus_rx_byte = 1'b1;
      tick();
      bus_rx_byte = 1'b0;
      check("R9 rx_over", 32'(status[1]), 32'h1);
      rx_lvl = RXW'(1); host_rx_rd = 1'b1;
      tick();
      host_rx_rd = 1'b0;
      check("R9 rx read not empty", 32'(status[0]), 32'h0);
      rx_lvl = RXW'(0); host_rx_rd = 1'b1;
      tick();
      host_rx_rd = 1'b0;
      check("R9 rx_under", 32'(status[0]), 32'h1);

      // R10 hold while disabled and busy, clear once idle
      enable = 1'b0; eng_busy = 1'b1;
      tick(); tick();
      check("R10 held while busy", 32'({status[3], status[1], status[0]}), 32'h7);
      check("R8 tx_empty busy", 32'(status[4]), 32'h1);
      eng_busy = 1'b0;
      tick();
      check("R10 cleared idle", 32'(status), 32'h0);

      summary();
   end
endmodule